// File: doc/BRIEF.md
# Memory Thermal Status and Refresh Policy Controller

This block keeps a nine-bit control register for DRAM power and thermal handling, plus four protected registers per memory channel: warm threshold, hot threshold, warm budget and hot budget. From three candidate thermal inputs it selects one effective status. The candidates are a closed-loop estimate, an open-loop estimate and an external indication. It then drives two registered refresh controls: a double-rate refresh request and a skip-refresh permission.

Firmware programs the block through a plain write strobe, an address and a write data word, and reads it back through a combinational read port. Once the configuration is final, firmware sets the lock bit. From then on the threshold and budget registers of every channel ignore writes until the next reset. A reserved code in the refresh-doubling field raises an error flag for as long as that code is held.

Top module: `memtherm_refresh_ctrl`

## Requirements
- R1: After reset the control register, every protected register and every output are zero.
- R2: The control register lives at address 0. Its fields are: open-loop enable bit 0, closed-loop enable bit 1, refresh-doubling mode bits 3:2, external enable bit 4, lock bit 5, power-down owner bit 6, DRAM-sensor disable bit 7, skip-refresh enable bit 8. Bits 31:9 read as zero and ignore writes. Unmapped addresses read as zero.
- R3: When the closed-loop enable is set, the closed-loop status is the algorithm status, whatever the open-loop enable holds. Otherwise, when the open-loop enable is set, the open-loop status is used. With neither set and the external enable clear, the status is COLD. Status codes are COLD=00, WARM=01, HOT=10.
- R4: With the external enable clear, the external input has no effect. With it set, the effective status is the hotter of the external and algorithm statuses when an algorithm is enabled, and the external status alone when none is.
- R5: Refresh-doubling mode 00 keeps double refresh off. Mode 01 turns it on for WARM or HOT. Mode 10 turns it on only for HOT.
- R6: Mode 11 holds the error output high while stored, and double refresh stays off.
- R7: Once the lock bit is written to 1, writes to all protected registers are dropped, and a write of 0 to the lock bit has no effect. Only reset clears the lock.
- R8: With the low-power DRAM flag set and the DRAM-sensor disable bit at 0, the mode field is ignored and double refresh follows the per-device temperature request input.
- R9: Skip refresh is on only when its enable bit is set and the DDR4 flag is high.
- R10: The effective status, double-refresh and skip-refresh outputs are registered. They reflect inputs and configuration one clock edge after those change.
- R11: A status input carrying code 11 is treated as HOT.
- R12: Channel c's protected register k (0 warm threshold, 1 hot threshold, 2 warm budget, 3 hot budget) sits at address PROT_BASE + 4c + k, holds THR_W bits and reads zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for write and read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| cl_status | input | 2 | Closed-loop thermal status |
| ol_status | input | 2 | Open-loop thermal status |
| ext_status | input | 2 | External thermal status |
| mem_is_lpddr | input | 1 | Memory is low-power DRAM |
| mem_is_ddr4 | input | 1 | Memory is DDR4 |
| dev_temp_2x | input | 1 | Per-device temperature report requests faster refresh |
| eff_status | output | 2 | Registered effective thermal status |
| refresh_2x | output | 1 | Registered double-rate refresh enable |
| skip_refresh | output | 1 | Registered skip-refresh enable |
| mode_err | output | 1 | Refresh-doubling mode holds the illegal code |

## Verification
The state that is hardest to reach from the ports is a lock that has been set while another write tries to clear it, followed by a reset that must release it. The stimulus first fills the protected registers and sets the lock. It then writes new values to every protected address, writes zero to the lock bit, and reads everything back. Next it pulses reset in the middle of the run and shows that writes take effect again. A long random phase then mixes control writes, protected writes and status changes, with the reference model tracking the lock state throughout.

// File: rtl/memtherm_pkg.sv
package memtherm_pkg;

   localparam int CTRL_W = 9;

   localparam logic [1:0] TS_COLD = 2'b00;
   localparam logic [1:0] TS_WARM = 2'b01;
   localparam logic [1:0] TS_HOT  = 2'b10;

   localparam logic [1:0] DBL_OFF  = 2'b00;
   localparam logic [1:0] DBL_WARM = 2'b01;
   localparam logic [1:0] DBL_HOT  = 2'b10;
   localparam logic [1:0] DBL_BAD  = 2'b11;

   typedef struct packed {
      logic       skip_en;
      logic       sensor_dis;
      logic       pdwn_own;
      logic       lock;
      logic       ext_en;
      logic [1:0] dbl_mode;
      logic       cl_en;
      logic       ol_en;
   } ctrl_t;

   function automatic logic [1:0] norm_status(input logic [1:0] s);
      return (s == 2'b11) ? TS_HOT : s;
   endfunction

endpackage

// File: rtl/memtherm_cfg_regs.sv
module memtherm_cfg_regs
   import memtherm_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int NUM_CH    = 2,
   parameter int THR_W     = 8,
   parameter int PROT_BASE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output ctrl_t             ctrl
);

   localparam int NREG = NUM_CH * 4;
   localparam int LOCK_BIT = 5;

   ctrl_t ctrl_q;
   ctrl_t ctrl_nxt;
   logic  ctrl_hit;
   logic [NREG-1:0][THR_W-1:0] prot_rd;

   assign ctrl_hit = wr && (addr == '0);

   always_comb begin
      ctrl_nxt      = ctrl_t'(wdata[CTRL_W-1:0]);
      ctrl_nxt.lock = ctrl_q.lock | wdata[LOCK_BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (ctrl_hit)
         ctrl_q <= ctrl_nxt;
   end

   for (genvar g = 0; g < NREG; g++) begin : g_prot
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PROT_BASE + g);
      logic [THR_W-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            r_q <= '0;
         else if (wr && (addr == MY_ADDR) && !ctrl_q.lock)
            r_q <= wdata[THR_W-1:0];
      end
      assign prot_rd[g] = r_q;
   end

   always_comb begin
      rdata = '0;
      if (addr == '0)
         rdata[CTRL_W-1:0] = ctrl_q;
      for (int i = 0; i < NREG; i++) begin
         if (addr == ADDR_W'(PROT_BASE + i))
            rdata[THR_W-1:0] = prot_rd[i];
      end
   end

   assign ctrl = ctrl_q;

   assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.lock |=> ctrl_q.lock);

   assert_locked_regs_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.lock |=> $stable(prot_rd));

   assert_upper_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == '0) |-> (rdata[DATA_W-1:CTRL_W] == '0));

endmodule

// File: rtl/memtherm_status_sel.sv
module memtherm_status_sel
   import memtherm_pkg::*;
#(
   parameter bit HAS_EXT = 1'b1
) (
   input  logic       cl_en,
   input  logic       ol_en,
   input  logic       ext_en,
   input  logic [1:0] cl_status,
   input  logic [1:0] ol_status,
   input  logic [1:0] ext_status,
   output logic [1:0] eff
);

   logic       has_alg;
   logic [1:0] alg;

   assign has_alg = cl_en | ol_en;

   always_comb begin
      if (cl_en)
         alg = norm_status(cl_status);
      else if (ol_en)
         alg = norm_status(ol_status);
      else
         alg = TS_COLD;
   end

   if (HAS_EXT) begin : g_ext
      logic [1:0] ext_n;
      assign ext_n = norm_status(ext_status);
      always_comb begin
         if (!ext_en)
            eff = alg;
         else if (!has_alg)
            eff = ext_n;
         else
            eff = (ext_n > alg) ? ext_n : alg;
      end
   end else begin : g_no_ext
      logic unused_ext;
      assign unused_ext = ext_en ^ (^ext_status);
      assign eff = alg;
   end

endmodule

// File: rtl/memtherm_refresh_policy.sv
module memtherm_refresh_policy
   import memtherm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] status_in,
   input  logic [1:0] mode,
   input  logic       lp_override,
   input  logic       dev_2x,
   input  logic       skip_en,
   input  logic       is_ddr4,
   output logic [1:0] status_q,
   output logic       dbl_q,
   output logic       skip_q,
   output logic       mode_bad
);

   logic dbl_d;

   always_comb begin
      if (lp_override)
         dbl_d = dev_2x;
      else begin
         unique case (mode)
            DBL_WARM: dbl_d = (status_in == TS_WARM) || (status_in == TS_HOT);
            DBL_HOT:  dbl_d = (status_in == TS_HOT);
            default:  dbl_d = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= TS_COLD;
         dbl_q    <= 1'b0;
         skip_q   <= 1'b0;
      end else begin
         status_q <= status_in;
         dbl_q    <= dbl_d;
         skip_q   <= skip_en & is_ddr4;
      end
   end

   assign mode_bad = (mode == DBL_BAD);

   assert_illegal_mode_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == DBL_BAD && !lp_override) |=> !dbl_q);

   assert_cold_no_double_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_in == TS_COLD && !lp_override) |=> !dbl_q);

   assert_skip_needs_ddr4_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !is_ddr4 |=> !skip_q);

endmodule

// File: rtl/memtherm_refresh_ctrl.sv
module memtherm_refresh_ctrl
   import memtherm_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int NUM_CH    = 2,
   parameter int THR_W     = 8,
   parameter int PROT_BASE = 16,
   parameter bit HAS_EXT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [1:0]        cl_status,
   input  logic [1:0]        ol_status,
   input  logic [1:0]        ext_status,
   input  logic              mem_is_lpddr,
   input  logic              mem_is_ddr4,
   input  logic              dev_temp_2x,
   output logic [1:0]        eff_status,
   output logic              refresh_2x,
   output logic              skip_refresh,
   output logic              mode_err
);

   localparam int NREG     = NUM_CH * 4;
   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (DATA_W < CTRL_W + 1) begin : g_chk_data
      $error("DATA_W too narrow for the control register");
   end
   if (THR_W < 1 || THR_W > DATA_W) begin : g_chk_thr
      $error("THR_W must lie between 1 and DATA_W");
   end
   if (NUM_CH < 1) begin : g_chk_ch
      $error("NUM_CH must be at least 1");
   end
   if (PROT_BASE < 1 || PROT_BASE + NREG > ADDR_SPAN) begin : g_chk_map
      $error("protected register window does not fit the address space");
   end

   ctrl_t      ctrl;
   logic [1:0] eff_d;

   memtherm_cfg_regs #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .NUM_CH   (NUM_CH),
      .THR_W    (THR_W),
      .PROT_BASE(PROT_BASE)
   ) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (reg_wr),
      .addr (reg_addr),
      .wdata(reg_wdata),
      .rdata(reg_rdata),
      .ctrl (ctrl)
   );

   memtherm_status_sel #(
      .HAS_EXT(HAS_EXT)
   ) u_sel (
      .cl_en     (ctrl.cl_en),
      .ol_en     (ctrl.ol_en),
      .ext_en    (ctrl.ext_en),
      .cl_status (cl_status),
      .ol_status (ol_status),
      .ext_status(ext_status),
      .eff       (eff_d)
   );

   memtherm_refresh_policy u_pol (
      .clk        (clk),
      .rst_n      (rst_n),
      .status_in  (eff_d),
      .mode       (ctrl.dbl_mode),
      .lp_override(mem_is_lpddr & ~ctrl.sensor_dis),
      .dev_2x     (dev_temp_2x),
      .skip_en    (ctrl.skip_en),
      .is_ddr4    (mem_is_ddr4),
      .status_q   (eff_status),
      .dbl_q      (refresh_2x),
      .skip_q     (skip_refresh),
      .mode_bad   (mode_err)
   );

   assert_status_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (eff_status != 2'b11));

   assert_ext_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.ext_en && !ctrl.cl_en && !ctrl.ol_en) |=> (eff_status == TS_COLD));

endmodule

// File: tb/memtherm_refresh_ctrl_tb.sv
module memtherm_refresh_ctrl_tb;

   localparam int DATA_W = 32;
   localparam int ADDR_W = 8;
   localparam int NUM_CH = 2;
   localparam int THR_W  = 8;
   localparam int PBASE  = 16;
   localparam int NREG   = NUM_CH * 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic [1:0]        cl_status = 2'b00, ol_status = 2'b00, ext_status = 2'b00;
   logic              mem_is_lpddr = 1'b0, mem_is_ddr4 = 1'b0, dev_temp_2x = 1'b0;
   logic [1:0]        eff_status;
   logic              refresh_2x, skip_refresh, mode_err;

   always #5 clk = ~clk;

   memtherm_refresh_ctrl #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH),
      .THR_W(THR_W), .PROT_BASE(PBASE), .HAS_EXT(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cl_status(cl_status),
      .ol_status(ol_status), .ext_status(ext_status), .mem_is_lpddr(mem_is_lpddr),
      .mem_is_ddr4(mem_is_ddr4), .dev_temp_2x(dev_temp_2x), .eff_status(eff_status),
      .refresh_2x(refresh_2x), .skip_refresh(skip_refresh), .mode_err(mode_err)
   );

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // reference model state
   int m_ctrl;
   int m_prot[NREG];
   int m_eff, m_dbl, m_skip;

   function automatic int bitof(int v, int b);
      return (v >> b) & 1;
   endfunction

   function automatic int hotness(int s);
      return (s == 3) ? 2 : s;
   endfunction

   function automatic int model_status();
      int picked = 0;
      bool_alg: begin end
      if (bitof(m_ctrl, 1) == 1) picked = hotness(cl_status);
      else if (bitof(m_ctrl, 0) == 1) picked = hotness(ol_status);
      if (bitof(m_ctrl, 4) == 1) begin
         if (bitof(m_ctrl, 0) == 0 && bitof(m_ctrl, 1) == 0)
            picked = hotness(ext_status);
         else if (hotness(ext_status) > picked)
            picked = hotness(ext_status);
      end
      return picked;
   endfunction

   function automatic int model_double(int st);
      int mode = (m_ctrl >> 2) & 3;
      if (mem_is_lpddr && bitof(m_ctrl, 7) == 0) return int'(dev_temp_2x);
      if (mode == 1) return (st >= 1) ? 1 : 0;
      if (mode == 2) return (st == 2) ? 1 : 0;
      return 0;
   endfunction

   function automatic int model_read(int a);
      if (a == 0) return m_ctrl;
      if (a >= PBASE && a < PBASE + NREG) return m_prot[a - PBASE];
      return 0;
   endfunction

   task automatic check(string req, int act, int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
      end
   endtask

   task automatic compare_all();
      check("R3 R4 R10 R11 eff_status", int'(eff_status), m_eff);
      check("R5 R8 R10 refresh_2x", int'(refresh_2x), m_dbl);
      check("R9 R10 skip_refresh", int'(skip_refresh), m_skip);
      check("R6 mode_err", int'(mode_err), (((m_ctrl >> 2) & 3) == 3) ? 1 : 0);
      check("R2 R7 R12 reg_rdata", int'(reg_rdata), model_read(int'(reg_addr)));
   endtask

   // one clock: inputs already set; optional write
   task automatic cyc(bit w, int a, int d);
      int st;
      reg_wr    = w;
      reg_addr  = ADDR_W'(a);
      reg_wdata = DATA_W'(d);
      @(posedge clk);
      st     = model_status();
      m_eff  = st;
      m_dbl  = model_double(st);
      m_skip = (bitof(m_ctrl, 8) == 1 && mem_is_ddr4) ? 1 : 0;
      if (w) begin
         if (a == 0)
            m_ctrl = (d & 32'h1FF) | (m_ctrl & 32'h20);
         else if (a >= PBASE && a < PBASE + NREG && bitof(m_ctrl, 5) == 0)
            m_prot[a - PBASE] = d & ((1 << THR_W) - 1);
      end
      @(negedge clk);
      reg_wr = 1'b0;
      compare_all();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      reg_wr = 1'b0;
      m_ctrl = 0; m_eff = 0; m_dbl = 0; m_skip = 0;
      foreach (m_prot[i]) m_prot[i] = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      compare_all();
   endtask

   task automatic rd(int a);
      cyc(1'b0, a, 0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1: reset state of registers
      rd(0);
      for (int i = 0; i < NREG; i++) rd(PBASE + i);

      // R3: no source -> COLD; open-loop; closed-loop wins
      ol_status = 2'b01; cl_status = 2'b10; ext_status = 2'b10;
      cyc(1'b1, 0, 32'h001); cyc(1'b0, 0, 0); cyc(1'b0, 0, 0);
      cyc(1'b1, 0, 32'h003); cyc(1'b0, 0, 0);
      cl_status = 2'b00; cyc(1'b0, 0, 0);
      // R11: code 11 seen as HOT
      cl_status = 2'b11; cyc(1'b0, 0, 0);

      // R4: external enabled, hotter wins; alone when no algorithm
      cl_status = 2'b01; ext_status = 2'b10;
      cyc(1'b1, 0, 32'h012); cyc(1'b0, 0, 0);
      ext_status = 2'b00; cyc(1'b0, 0, 0);
      cyc(1'b1, 0, 32'h010); ext_status = 2'b01; cyc(1'b0, 0, 0);
      ext_status = 2'b11; cyc(1'b0, 0, 0);

      // R5/R6: each mode with each status
      for (int mode = 0; mode < 4; mode++) begin
         cyc(1'b1, 0, 32'h002 | (mode << 2));
         for (int s = 0; s < 3; s++) begin
            cl_status = 2'(s);
            cyc(1'b0, 0, 0);
            cyc(1'b0, 0, 0);
         end
      end

      // R8: low-power override then sensor disable
      mem_is_lpddr = 1'b1; cl_status = 2'b10;
      cyc(1'b1, 0, 32'h006);
      dev_temp_2x = 1'b0; cyc(1'b0, 0, 0); cyc(1'b0, 0, 0);
      dev_temp_2x = 1'b1; cyc(1'b0, 0, 0);
      cyc(1'b1, 0, 32'h086); dev_temp_2x = 1'b0; cyc(1'b0, 0, 0); cyc(1'b0, 0, 0);
      mem_is_lpddr = 1'b0;

      // R9: skip needs both
      cyc(1'b1, 0, 32'h100); cyc(1'b0, 0, 0);
      mem_is_ddr4 = 1'b1; cyc(1'b0, 0, 0); cyc(1'b0, 0, 0);
      cyc(1'b1, 0, 32'h000); cyc(1'b0, 0, 0);

      // R2: reserved bits ignored, unmapped reads zero
      cyc(1'b1, 0, 32'hFFFF_FEDF); rd(0); rd(3); rd(PBASE + NREG);
      cyc(1'b1, 0, 32'h0); rd(0);

      // R12: protected registers addressable and width-limited
      for (int i = 0; i < NREG; i++) cyc(1'b1, PBASE + i, 32'hA500 + i * 17);
      for (int i = 0; i < NREG; i++) rd(PBASE + i);

      // R7: lock, blocked writes, unclearable by write
      cyc(1'b1, 0, 32'h020);
      for (int i = 0; i < NREG; i++) cyc(1'b1, PBASE + i, 32'h5A);
      for (int i = 0; i < NREG; i++) rd(PBASE + i);
      cyc(1'b1, 0, 32'h000); rd(0);
      cyc(1'b1, PBASE, 32'h33); rd(PBASE);
      // R7: reset releases
      do_reset();
      rd(0);
      cyc(1'b1, PBASE + 1, 32'h77); rd(PBASE + 1);

      // random mix
      for (int n = 0; n < 3000; n++) begin
         int sel = $urandom_range(0, 9);
         int a;
         cl_status    = 2'($urandom);
         ol_status    = 2'($urandom);
         ext_status   = 2'($urandom);
         mem_is_lpddr = 1'($urandom);
         mem_is_ddr4  = 1'($urandom);
         dev_temp_2x  = 1'($urandom);
         if (n == 1500) do_reset();
         if (sel < 3) a = 0;
         else if (sel < 8) a = PBASE + $urandom_range(0, NREG - 1);
         else a = $urandom_range(0, 255);
         if (a == 0 && $urandom_range(0, 7) != 0)
            cyc(1'($urandom), a, int'($urandom) & ~32'h20);
         else
            cyc(1'($urandom), a, int'($urandom));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule